// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration space of a type-0 endpoint device and exposes it through a plain byte port: one address, one write byte, a write strobe, and a registered read byte. Identity bytes (vendor, device, revision, class code and interrupt pin) come from parameters and cannot be overwritten. The header-type byte and the self-test byte always read as zero.

Six base address registers sit in the header. Each one is configured by parameters as absent, an I/O window or a 32-bit memory window, and each has a size. After every byte write, the register is masked so that software can size the window by writing all ones and reading the value back. A write to the command byte drives the I/O and memory decode enables and raises a one-cycle update pulse. A write to the expansion-ROM address bytes raises a sticky flag, which stays set until it is acknowledged.

Top module: `cfg_header_regs`

## Requirements
- R1: Offsets 0x00/0x01 (vendor ID, low byte first), 0x02/0x03 (device ID), 0x08 (revision), 0x09 (programming interface), 0x0A (subclass), 0x0B (base class) and 0x3D (interrupt pin) read their parameter values, and writes to them have no effect.
- R2: Offset 0x0E (header type) always reads 0x00, and writes to it have no effect.
- R3: Base register n occupies offsets 0x10+4n to 0x13+4n, least significant byte first. A write to any of its bytes replaces that byte, and then the whole 32-bit value is ANDed with the register's mask. For an I/O window of P ports the mask is ~(P-1)|0x1. For a memory window of G 4-KiB pages it is ~(G*4096-1)|0xF. Writing all ones to every byte therefore reads back as the mask.
- R4: At reset an I/O base register reads 0x00000001 and a memory base register reads 0x00000008. An absent base register always reads zero and ignores writes.
- R5: A write to offset 0x04 stores the byte, which reads back. From the next edge onward, ioEnable equals its bit 0 and memEnable equals its bit 1. cmdUpdated is high for exactly the one cycle after each such write edge.
- R6: A write to any of offsets 0x30 to 0x33 stores the byte and sets romUpdated, which stays set until romAck is sampled high. If a ROM write and romAck fall in the same cycle, the flag ends up set.
- R7: Offset 0x0F (self-test) always reads 0x00, whatever was written to it.
- R8: Every other offset is a plain read/write byte that resets to 0x00.
- R9: rdData takes, at each rising edge, the value at the address present before that edge. A write lands on the same edge, so a read in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address for reads and writes |
| wrData | input | 8 | Write byte |
| wrEn | input | 1 | Write strobe |
| romAck | input | 1 | Clears the expansion-ROM update flag |
| rdData | output | 8 | Registered read byte |
| ioEnable | output | 1 | Command bit 0 |
| memEnable | output | 1 | Command bit 1 |
| cmdUpdated | output | 1 | One-cycle pulse after a command write |
| romUpdated | output | 1 | Sticky expansion-ROM write flag |

## Verification
The assertions assume that addr, wrData, wrEn and romAck are known values and are stable across each rising edge. Under that assumption, any $past of those inputs describes the access that actually landed. The stimulus keeps to this by changing every input only on the falling edge and by driving every bit to 0 or 1 from the first cycle. The random address draw favours the 64-byte header, and the directed cases cover all-ones sizing, absent registers and a ROM write that coincides with an acknowledge.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_BARS = 6;
  localparam int CNT_W    = 20;
  localparam int BAR_W    = 32;

  localparam logic [ADDR_W-1:0] OFS_CMD      = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_HDRTYPE  = 8'h0E;
  localparam logic [ADDR_W-1:0] OFS_SELFTEST = 8'h0F;
  localparam logic [ADDR_W-1:0] OFS_BAR_LO   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_BAR_HI   = 8'h27;
  localparam logic [ADDR_W-1:0] OFS_ROM_LO   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ROM_HI   = 8'h33;
  localparam logic [ADDR_W-1:0] OFS_INTPIN   = 8'h3D;

  typedef enum logic [1:0] {
    BAR_NONE = 2'd0,
    BAR_IO   = 2'd1,
    BAR_MEM  = 2'd2
  } barKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       storeWr;
    logic       barWr;
    logic [2:0] barIdx;
    logic [1:0] lane;
  } cfgStrobe_t;

  function automatic logic isIdentity(input logic [ADDR_W-1:0] a);
    return (a <= 8'h03) || ((a >= 8'h08) && (a <= 8'h0B)) || (a == OFS_INTPIN);
  endfunction

  function automatic logic [BAR_W-1:0] barMask(input barKind_e kind,
                                               input logic [CNT_W-1:0] count);
    logic [BAR_W-1:0] span;
    span = 32'(count);
    if (kind == BAR_IO)  return ~(span - 32'd1) | 32'h1;
    if (kind == BAR_MEM) return ~((span << 12) - 32'd1) | 32'hF;
    return '0;
  endfunction

  function automatic logic [BAR_W-1:0] barReset(input barKind_e kind);
    if (kind == BAR_IO)  return 32'h1;
    if (kind == BAR_MEM) return 32'h8;
    return '0;
  endfunction

endpackage

// File: rtl/cfg_hdr_bar.sv
module cfg_hdr_bar
  import cfg_hdr_pkg::*;
#(
  parameter barKind_e         KIND  = BAR_NONE,
  parameter logic [CNT_W-1:0] COUNT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] wrByte,
  output logic [BAR_W-1:0]  barQ
);

  localparam logic [BAR_W-1:0] MASK    = barMask(KIND, COUNT);
  localparam logic [BAR_W-1:0] RST_VAL = barReset(KIND);

  logic [BAR_W-1:0] merged;

  always_comb begin
    merged = barQ;
    merged[8*lane +: 8] = wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     barQ <= RST_VAL;
    else if (wrEn) barQ <= merged & MASK;
  end

  // R3: the written lane lands masked
  p_lane_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((barQ >> {$past(lane), 3'b000}) & 32'hFF) ==
             ((32'($past(wrByte)) & (MASK >> {$past(lane), 3'b000})) & 32'hFF));

  // R3: no write, no change
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(barQ));

  generate
    if (KIND == BAR_NONE) begin : g_absent
      // R4: absent register stays zero
      p_absent_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
        wrEn |=> barQ == '0);
    end
  endgenerate

endmodule

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              romAck,
  output cfgStrobe_t        strobe,
  output logic              cmdUpdated,
  output logic              romUpdated
);

  logic             barHit;
  logic             cmdHit;
  logic             romHit;
  logic             lockedByte;
  logic [ADDR_W-1:0] barOfs;

  always_comb begin
    barHit     = (addr >= OFS_BAR_LO) && (addr <= OFS_BAR_HI);
    barOfs     = addr - OFS_BAR_LO;
    lockedByte = isIdentity(addr) || (addr == OFS_HDRTYPE) || (addr == OFS_SELFTEST);
    cmdHit     = wrEn && (addr == OFS_CMD);
    romHit     = wrEn && (addr >= OFS_ROM_LO) && (addr <= OFS_ROM_HI);

    strobe.barWr   = wrEn && barHit;
    strobe.barIdx  = barOfs[4:2];
    strobe.lane    = barOfs[1:0];
    strobe.storeWr = wrEn && !barHit && !lockedByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdUpdated <= 1'b0;
      romUpdated <= 1'b0;
    end else begin
      cmdUpdated <= cmdHit;
      if (romHit)      romUpdated <= 1'b1;
      else if (romAck) romUpdated <= 1'b0;
    end
  end

  // R6: flag holds until acknowledged
  p_rom_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (romUpdated && !romAck) |=> romUpdated);

  // R6: a ROM write always leaves the flag set
  p_rom_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[7:2] == 6'b001100) |=> romUpdated);

  // R6: an ack without a ROM write clears it
  p_rom_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (romAck && !(wrEn && addr[7:2] == 6'b001100)) |=> !romUpdated);

  // R2 R7: locked bytes never raise a storage strobe
  p_locked_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == OFS_HDRTYPE || addr == OFS_SELFTEST) |-> !strobe.storeWr && !strobe.barWr);

endmodule

// File: rtl/cfg_hdr_datapath.sv
module cfg_hdr_datapath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]               VENDOR_ID  = 16'hBEEF,
  parameter logic [15:0]               DEVICE_ID  = 16'h0C42,
  parameter logic [7:0]                REVISION   = 8'h03,
  parameter logic [7:0]                PROG_IF    = 8'h00,
  parameter logic [7:0]                SUB_CLASS  = 8'h00,
  parameter logic [7:0]                BASE_CLASS = 8'h06,
  parameter logic [7:0]                INT_PIN    = 8'h01,
  parameter logic [2*NUM_BARS-1:0]     BAR_KINDS  = 12'b00_01_00_10_01_10,
  parameter logic [CNT_W*NUM_BARS-1:0] BAR_COUNTS = {20'd0, 20'd256, 20'd0, 20'd1, 20'd32, 20'd4}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  cfgStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cmdByte
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cfgMem [DEPTH];
  logic [BAR_W-1:0]  barVal [NUM_BARS];
  logic [DATA_W-1:0] rdNext;
  logic [ADDR_W-1:0] barOfs;

  genvar g;
  generate
    for (g = 0; g < NUM_BARS; g++) begin : g_bar
      cfg_hdr_bar #(
        .KIND  (barKind_e'(BAR_KINDS[2*g +: 2])),
        .COUNT (BAR_COUNTS[CNT_W*g +: CNT_W])
      ) i_bar (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (strobe.barWr && (strobe.barIdx == 3'(g))),
        .lane   (strobe.lane),
        .wrByte (wrData),
        .barQ   (barVal[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cfgMem[i] <= '0;
    end else if (strobe.storeWr) begin
      cfgMem[addr] <= wrData;
    end
  end

  assign cmdByte = cfgMem[OFS_CMD];

  always_comb begin
    barOfs = addr - OFS_BAR_LO;
    case (addr)
      8'h00:        rdNext = VENDOR_ID[7:0];
      8'h01:        rdNext = VENDOR_ID[15:8];
      8'h02:        rdNext = DEVICE_ID[7:0];
      8'h03:        rdNext = DEVICE_ID[15:8];
      8'h08:        rdNext = REVISION;
      8'h09:        rdNext = PROG_IF;
      8'h0A:        rdNext = SUB_CLASS;
      8'h0B:        rdNext = BASE_CLASS;
      OFS_INTPIN:   rdNext = INT_PIN;
      OFS_HDRTYPE:  rdNext = '0;
      OFS_SELFTEST: rdNext = '0;
      default: begin
        if ((addr >= OFS_BAR_LO) && (addr <= OFS_BAR_HI))
          rdNext = barVal[barOfs[4:2]][8*barOfs[1:0] +: 8];
        else
          rdNext = cfgMem[addr];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // R7: self-test byte reads zero
  p_selftest_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addr == OFS_SELFTEST) |=> rdData == 8'h00);

  // R2: header type reads zero
  p_hdrtype_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == OFS_HDRTYPE) |=> rdData == 8'h00);

  // R1: vendor low byte is fixed
  p_vendor_fixed_r1: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 8'h00) |=> rdData == VENDOR_ID[7:0]);

  // R8: plain bytes keep what was written
  p_plain_store_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeWr |=> cfgMem[$past(addr)] == $past(wrData));

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]               VENDOR_ID  = 16'hBEEF,
  parameter logic [15:0]               DEVICE_ID  = 16'h0C42,
  parameter logic [7:0]                REVISION   = 8'h03,
  parameter logic [7:0]                PROG_IF    = 8'h00,
  parameter logic [7:0]                SUB_CLASS  = 8'h00,
  parameter logic [7:0]                BASE_CLASS = 8'h06,
  parameter logic [7:0]                INT_PIN    = 8'h01,
  parameter logic [2*NUM_BARS-1:0]     BAR_KINDS  = 12'b00_01_00_10_01_10,
  parameter logic [CNT_W*NUM_BARS-1:0] BAR_COUNTS = {20'd0, 20'd256, 20'd0, 20'd1, 20'd32, 20'd4}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              romAck,
  output logic [DATA_W-1:0] rdData,
  output logic              ioEnable,
  output logic              memEnable,
  output logic              cmdUpdated,
  output logic              romUpdated
);

  cfgStrobe_t        strobe;
  logic [DATA_W-1:0] cmdByte;

  cfg_hdr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .wrEn       (wrEn),
    .romAck     (romAck),
    .strobe     (strobe),
    .cmdUpdated (cmdUpdated),
    .romUpdated (romUpdated)
  );

  cfg_hdr_datapath #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REVISION   (REVISION),
    .PROG_IF    (PROG_IF),
    .SUB_CLASS  (SUB_CLASS),
    .BASE_CLASS (BASE_CLASS),
    .INT_PIN    (INT_PIN),
    .BAR_KINDS  (BAR_KINDS),
    .BAR_COUNTS (BAR_COUNTS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData),
    .cmdByte (cmdByte)
  );

  assign ioEnable  = cmdByte[0];
  assign memEnable = cmdByte[1];

  // R5: enables follow the command byte that raised the pulse
  p_cmd_enables_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdUpdated |-> (ioEnable == $past(wrData[0])) && (memEnable == $past(wrData[1])));

  // R5: enables only move with a command write
  p_cmd_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmdUpdated |-> $stable(ioEnable) && $stable(memEnable));

endmodule

// File: tb/test_cfg_header_regs.sv
module test_cfg_header_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       romAck = 1'b0;
  logic [7:0] rdData;
  logic       ioEnable, memEnable, cmdUpdated, romUpdated;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_header_regs #(
    .VENDOR_ID  (16'hBEEF),
    .DEVICE_ID  (16'h0C42),
    .REVISION   (8'h03),
    .PROG_IF    (8'h00),
    .SUB_CLASS  (8'h00),
    .BASE_CLASS (8'h06),
    .INT_PIN    (8'h01),
    .BAR_KINDS  (12'b00_01_00_10_01_10),
    .BAR_COUNTS ({20'd0, 20'd256, 20'd0, 20'd1, 20'd32, 20'd4})
  ) i_cfg_header_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .romAck(romAck), .rdData(rdData), .ioEnable(ioEnable), .memEnable(memEnable),
    .cmdUpdated(cmdUpdated), .romUpdated(romUpdated)
  );

  // reference model, 0 none / 1 io / 2 mem
  int          bKind  [6] = '{2, 1, 2, 0, 1, 0};
  int unsigned bCount [6] = '{4, 32, 1, 0, 256, 0};
  logic [7:0]  refMem [256];
  logic [31:0] refBar [6];
  bit          refRom;

  function automatic logic [31:0] maskOf(int i);
    if (bKind[i] == 1) return ~(bCount[i] - 1) | 32'h1;
    if (bKind[i] == 2) return ~(bCount[i] * 4096 - 1) | 32'hF;
    return 32'h0;
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return 8'hEF;
      8'h01: return 8'hBE;
      8'h02: return 8'h42;
      8'h03: return 8'h0C;
      8'h08: return 8'h03;
      8'h09: return 8'h00;
      8'h0A: return 8'h00;
      8'h0B: return 8'h06;
      8'h3D: return 8'h01;
      8'h0E, 8'h0F: return 8'h00;
      default: begin
        if (a >= 8'h10 && a <= 8'h27)
          return refBar[(a - 8'h10) / 4][8*((a - 8'h10) % 4) +: 8];
        return refMem[a];
      end
    endcase
  endfunction

  function automatic bit isLocked(logic [7:0] a);
    return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || a == 8'h3D || a == 8'h0E || a == 8'h0F;
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [7:0] d);
    if (a >= 8'h10 && a <= 8'h27) begin
      int n = (a - 8'h10) / 4;
      int l = (a - 8'h10) % 4;
      refBar[n][8*l +: 8] = d;
      refBar[n] = refBar[n] & maskOf(n);
    end else if (!isLocked(a)) begin
      refMem[a] = d;
    end
    if (a >= 8'h30 && a <= 8'h33) refRom = 1;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // at a falling edge: read, one edge, compare
  task automatic doRead(logic [7:0] a, string req);
    addr = a; wrEn = 0;
    @(negedge clk);
    check(rdData == expRead(a), req, 32'(rdData), 32'(expRead(a)));
  endtask

  task automatic doWrite(logic [7:0] a, logic [7:0] d, bit ack = 0);
    logic [7:0] oldVal;
    oldVal = expRead(a);
    addr = a; wrData = d; wrEn = 1; romAck = ack;
    @(negedge clk);
    wrEn = 0; romAck = 0;
    if (ack) refRom = 0;
    modelWrite(a, d);
    // R9: same-cycle read returns pre-write value
    check(rdData == oldVal, "R9", 32'(rdData), 32'(oldVal));
    check(cmdUpdated == (a == 8'h04), "R5 pulse", 32'(cmdUpdated), 32'(a == 8'h04));
    check(ioEnable == refMem[4][0] && memEnable == refMem[4][1], "R5 enables",
          {ioEnable, memEnable}, {refMem[4][0], refMem[4][1]});
    check(romUpdated == refRom, "R6", 32'(romUpdated), 32'(refRom));
  endtask

  task automatic doAck();
    romAck = 1;
    @(negedge clk);
    romAck = 0; refRom = 0;
    check(romUpdated == 0, "R6 ack", 32'(romUpdated), 32'h0);
  endtask

  task automatic readBar(int n, string req);
    for (int l = 0; l < 4; l++) doRead(8'(8'h10 + 4*n + l), req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = '0;
    for (int i = 0; i < 6; i++) refBar[i] = (bKind[i] == 1) ? 32'h1 : (bKind[i] == 2) ? 32'h8 : 32'h0;
    refRom = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;

    // R4 R8 reset state
    check(ioEnable == 0 && memEnable == 0 && cmdUpdated == 0 && romUpdated == 0,
          "R4 reset outputs", {ioEnable, memEnable, cmdUpdated, romUpdated}, 32'h0);
    for (int n = 0; n < 6; n++) readBar(n, "R4 reset bar");
    doRead(8'h40, "R8 reset plain");
    for (int a = 0; a < 12; a++) doRead(8'(a), "R1 identity");
    doRead(8'h3D, "R1 intpin");

    // R1 R2 R7 locked bytes
    doWrite(8'h00, 8'h12); doRead(8'h00, "R1 vendor write");
    doWrite(8'h0B, 8'h99); doRead(8'h0B, "R1 class write");
    doWrite(8'h3D, 8'h77); doRead(8'h3D, "R1 intpin write");
    doWrite(8'h0E, 8'h80); doRead(8'h0E, "R2");
    doWrite(8'h0F, 8'hC0); doRead(8'h0F, "R7");

    // R3 sizing with all ones
    for (int n = 0; n < 6; n++) begin
      for (int l = 0; l < 4; l++) doWrite(8'(8'h10 + 4*n + l), 8'hFF);
      readBar(n, "R3 sizing");
    end
    doWrite(8'h11, 8'h00); readBar(0, "R3 partial");
    doWrite(8'h1C, 8'hAB); readBar(3, "R4 absent");

    // R5 command
    doWrite(8'h04, 8'h03); doRead(8'h04, "R5 readback");
    doRead(8'h04, "R5 hold");
    check(cmdUpdated == 0, "R5 single pulse", 32'(cmdUpdated), 32'h0);
    doWrite(8'h04, 8'h02);
    doWrite(8'h05, 8'h01); doRead(8'h05, "R8 cmd high");

    // R6 ROM flag
    doWrite(8'h32, 8'h5A); doRead(8'h32, "R6 store");
    doRead(8'h40, "R6 sticky");
    check(romUpdated == 1, "R6 sticky", 32'(romUpdated), 32'h1);
    doAck();
    doWrite(8'h31, 8'h11, 1);

    // R8 R9 plain
    doWrite(8'h40, 8'h5A); doWrite(8'h40, 8'hA5); doRead(8'h40, "R8 plain");
    doWrite(8'hFF, 8'h3C); doRead(8'hFF, "R8 top");

    // mixed random traffic
    for (int k = 0; k < 1500; k++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 6) ? 8'($urandom_range(0, 63)) : 8'($urandom);
      if (sel == 9) doAck();
      else if ($urandom_range(0, 1) == 1) doWrite(a, 8'($urandom), $urandom_range(0, 7) == 0);
      else doRead(a, "R3 R8 random");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule